// File: doc/BRIEF.md
# BCD Calendar Clock Keeper

This block holds a running time of day and calendar date in packed BCD and keeps it current by itself. An outside supplier, which may run in another clock domain, hands over a 65-bit date/time word. Bit 64 of that word is a change flag. The supplier inverts it each time it presents a new value. The block passes the flag through a synchronizer. When the synchronized flag differs from the last flag value it accepted, the block copies the word into its own time registers.

Between loads, a one-cycle pulse arriving once per second advances the stored time. Each field carries into the next using BCD arithmetic. The day count follows the length of the month, including a leap-year February. The weekday counts along with the date. The supplier only needs to deliver a value once after reset.

The current time is presented in the same 65-bit layout, so a downstream peripheral model can read it directly. On the output, bit 64 is a change flag of the block's own.

Top module: `bcd_calendar_keeper`

## Requirements
- R1: After reset the output is seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 0, with bit 64 low. As a whole it reads 65'h0_40_00_00_01_01_00_00_00.
- R2: Word layout, from bit 0 upward: seconds 7:0, minutes 15:8, hours 23:16, day 31:24, month 39:32, year 47:40, weekday 55:48. A load happens when input bit 64 differs from the flag value last accepted. The flag passes through SYNC_STAGES flip-flops, so the new time appears SYNC_STAGES+1 rising edges after the flag changes. Changes to the input data while the flag stays the same have no effect.
- R3: A tick with no load advances seconds by one in BCD. With neither a tick nor a load, the output holds.
- R4: Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00 and carry into the day.
- R5: The day rolls to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12. The month then advances.
- R6: February ends after day 29 when the BCD year is a multiple of 4, and after day 28 otherwise.
- R7: Month 12 rolls to 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday (range 0 to 6) advances on every day rollover and wraps from 6 to 0.
- R9: When a load and a tick occur on the same edge, the loaded value is stored and the tick is discarded.
- R10: Output bits 63:56 always read 0x40, whatever the input carries in those bits.
- R11: Output bit 64 inverts on exactly those edges where the stored time changes. A load of the value already held leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_word_i | input | 65 | Date/time word from the supplier, with its change flag in bit 64 |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| time_o | output | 65 | Current packed time, with the block's own change flag in bit 64 |

## Verification
The bench targets the carry boundaries:
- 59 seconds, 59 minutes, 23 hours
- the last day of 30-day and 31-day months
- February in leap years, both with an even tens digit (24) and an odd tens digit (12), and in ordinary years (10, 23)
- December 31 and year 99

A wrong month table or leap test would land on a day 31, 30 or 29 that does not exist, or skip February 29. The bench also checks the load latency against the synchronizer depth, and confirms that data changes without a flag flip are ignored. A design that loaded on data rather than on the flag would accept stale or half-written words. Finally, the bench drives a tick onto the exact load edge and loads a value equal to the one already held. These catch a tick that overrides the load, and an output flag that flips when nothing changed.

// File: rtl/calk_pkg.sv
// Package: shared types and BCD calendar helper functions for the clock keeper.
// Assumes all stored fields hold valid two-digit BCD, apart from the weekday,
// which is a plain binary value.
package calk_pkg;

    localparam int FIELD_W = 8;
    localparam int NUM_FIELDS = 7;
    localparam int CAL_W = FIELD_W * NUM_FIELDS;

    // Packed calendar; the member order matches the bit layout of the word.
    typedef struct packed {
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] yr;
        logic [FIELD_W-1:0] mon;
        logic [FIELD_W-1:0] day;
        logic [FIELD_W-1:0] hr;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
    } cal_t;

    // Add one to a two-digit BCD value.
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // A BCD year is a multiple of 4 when:
    //   the tens digit is even and the units digit is 0, 4 or 8, or
    //   the tens digit is odd and the units digit is 2 or 6.
    function automatic logic bcd_leap(input logic [FIELD_W-1:0] y);
        logic r;
        if (y[4] == 1'b0) begin
            r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        end else begin
            r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        end
        return r;
    endfunction

    // Last day (in BCD) of a BCD month, for a given BCD year.
    function automatic logic [FIELD_W-1:0] last_day(input logic [FIELD_W-1:0] m,
                                                     input logic [FIELD_W-1:0] y);
        logic [FIELD_W-1:0] r;
        case (m)
            8'h02:                      r = bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/calk_flag_sync.sv
// Module: brings the supplier's change flag into the local clock domain and
// raises load_o while the synchronized flag differs from the last one taken.
// Assumes the supplier holds its data stable for at least STAGES+1 cycles
// after it flips the flag.
module calk_flag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic load_o
);

    logic [STAGES-1:0] chain;
    logic              taken;

    // Shift the raw flag through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= flag_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Remember the flag value of the most recent load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= 1'b0;
        end else begin
            taken <= chain[STAGES-1];
        end
    end

    // A load is due while the synchronized flag differs from the one taken.
    always_comb begin
        load_o = chain[STAGES-1] ^ taken;
    end

endmodule

// File: rtl/calk_advance.sv
// Module: combinational one-second step of a packed BCD calendar.
// Carries run seconds -> minutes -> hours -> day (and weekday) -> month -> year.
// Values at or above a field's limit also roll over, so an out-of-range
// loaded value returns to range on its next carry.
module calk_advance
    import calk_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);

    logic c_min, c_hr, c_day, c_mon, c_yr;
    logic [FIELD_W-1:0] month_end;

    // Work out the month length for the current month and year.
    always_comb begin
        month_end = last_day(cur_i.mon, cur_i.yr);
    end

    // Ripple the carry up through the fields.
    always_comb begin
        nxt_o = cur_i;
        c_min = (cur_i.sec >= 8'h59);
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;

        nxt_o.sec = c_min ? 8'h00 : bcd_inc(cur_i.sec);

        if (c_min) begin
            c_hr      = (cur_i.min >= 8'h59);
            nxt_o.min = c_hr ? 8'h00 : bcd_inc(cur_i.min);
        end

        if (c_hr) begin
            c_day    = (cur_i.hr >= 8'h23);
            nxt_o.hr = c_day ? 8'h00 : bcd_inc(cur_i.hr);
        end

        if (c_day) begin
            c_mon     = (cur_i.day >= month_end);
            nxt_o.day = c_mon ? 8'h01 : bcd_inc(cur_i.day);
            nxt_o.dow = (cur_i.dow >= 8'd6) ? 8'd0 : cur_i.dow + 8'd1;
        end

        if (c_mon) begin
            c_yr      = (cur_i.mon >= 8'h12);
            nxt_o.mon = c_yr ? 8'h01 : bcd_inc(cur_i.mon);
        end

        if (c_yr) begin
            nxt_o.yr = (cur_i.yr >= 8'h99) ? 8'h00 : bcd_inc(cur_i.yr);
        end
    end

endmodule

// File: rtl/bcd_calendar_keeper.sv
// Module: top of the BCD calendar clock keeper.
// Takes a packed date/time word when the supplier's change flag flips, and
// otherwise advances once per tick_i pulse.
// Assumes tick_i is a single-cycle pulse at 1 Hz in the clk domain.
module bcd_calendar_keeper
    import calk_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  MARKER      = 8'h40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [64:0] load_word_i,
    input  logic        tick_i,
    output logic [64:0] time_o
);

    localparam int   FLAG_BIT  = CAL_W + FIELD_W;
    localparam cal_t CAL_RESET = '{dow: 8'd0, yr: 8'h00, mon: 8'h01, day: 8'h01,
                                   hr: 8'h00, min: 8'h00, sec: 8'h00};

    cal_t cur;
    cal_t stepped;
    cal_t upcoming;
    logic load_pulse;
    logic out_flag;
    logic unused_marker_in;

    // The supplier's marker byte is not used; the output carries its own.
    assign unused_marker_in = ^load_word_i[FLAG_BIT-1:CAL_W];

    calk_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (load_word_i[FLAG_BIT]),
        .load_o (load_pulse)
    );

    calk_advance u_step (
        .cur_i (cur),
        .nxt_o (stepped)
    );

    // Choose the next stored value; a load takes priority over a tick.
    always_comb begin
        if (load_pulse) begin
            upcoming = cal_t'(load_word_i[CAL_W-1:0]);
        end else if (tick_i) begin
            upcoming = stepped;
        end else begin
            upcoming = cur;
        end
    end

    // Store the time, and invert the output flag whenever the value changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= CAL_RESET;
            out_flag <= 1'b0;
        end else begin
            cur      <= upcoming;
            out_flag <= out_flag ^ (upcoming != cur);
        end
    end

    // Pack the output word.
    always_comb begin
        time_o = {out_flag, MARKER, cur};
    end

endmodule

// File: rtl/calk_checker.sv
// Module: assertion checker for bcd_calendar_keeper, attached by bind below.
module calk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        load_i,
    input logic [55:0] word_i,
    input logic [64:0] time_i
);

    AST_MARKER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        time_i[63:56] == 8'h40); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(time_i)); // R3

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && time_i[7:0] == 8'h59) |=> time_i[7:0] == 8'h00); // R4

    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && time_i[23:0] == 24'h235959) |=> time_i[23:0] == 24'h000000); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> time_i[55:0] == $past(word_i)); // R9

    AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (time_i[55:0] != $past(time_i[55:0])) == (time_i[64] != $past(time_i[64]))); // R11

endmodule

bind bcd_calendar_keeper calk_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .load_i (load_pulse),
    .word_i (load_word_i[55:0]),
    .time_i (time_o)
);

// File: tb/sim_bcd_calendar_keeper.sv
// Directed bench for bcd_calendar_keeper: one task per scenario.
module sim_bcd_calendar_keeper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [64:0] load_word_i = '0;
    logic        tick_i = 1'b0;
    logic [64:0] time_o;
    logic        tog = 1'b0;
    logic        done = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    bcd_calendar_keeper u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_word_i (load_word_i),
        .tick_i      (tick_i),
        .time_o      (time_o)
    );

    always #4 clk = ~clk;

    function automatic logic [55:0] f(input logic [7:0] dw, input logic [7:0] yr,
                                      input logic [7:0] mo, input logic [7:0] dy,
                                      input logic [7:0] hr, input logic [7:0] mi,
                                      input logic [7:0] se);
        return {dw, yr, mo, dy, hr, mi, se};
    endfunction

    task automatic check(input logic [64:0] act, input logic [64:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_time(input logic [55:0] exp, input string tag);
        check({1'b0, time_o[63:0]}, {1'b0, 8'h40, exp}, tag);
    endtask

    // Flip the flag with new data and wait past the load latency.
    task automatic do_load(input logic [55:0] w);
        tog = ~tog;
        load_word_i = {tog, 8'hAA, w};
        repeat (4) @(negedge clk);
    endtask

    task automatic do_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic step_from(input logic [55:0] start, input logic [55:0] exp, input string tag);
        do_load(start);
        do_tick();
        check_time(exp, tag);
    endtask

    task automatic t_reset();
        check(time_o, 65'h0_40_00_00_01_01_00_00_00, "R1 reset value");
        check({57'd0, time_o[63:56]}, 65'h40, "R10 marker after reset");
    endtask

    task automatic t_load();
        logic [55:0] w;
        w = f(8'd5, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h56);
        tog = ~tog;
        load_word_i = {tog, 8'hAA, w};
        @(negedge clk);
        @(negedge clk);
        check_time(f(8'd0, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R2 not loaded before latency");
        @(negedge clk);
        check_time(w, "R2 loaded after SYNC_STAGES+1 edges, R10 marker");
        load_word_i[55:0] = f(8'd1, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11, 8'h11);
        repeat (5) @(negedge clk);
        check_time(w, "R2 data change without flag ignored");
    endtask

    task automatic t_tick();
        do_load(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h56));
        do_tick();
        check_time(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h57), "R3 tick adds a second");
        do_tick();
        check_time(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h58), "R3 second tick");
        repeat (6) @(negedge clk);
        check_time(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h58), "R3 idle holds");
        step_from(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h09),
                  f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h34, 8'h10), "R3 BCD digit carry 09->10");
    endtask

    task automatic t_carry();
        step_from(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h03, 8'h15, 8'h13, 8'h00, 8'h00), "R4 minute/hour carry");
        step_from(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h23, 8'h59, 8'h59),
                  f(8'd3, 8'h24, 8'h03, 8'h16, 8'h00, 8'h00, 8'h00), "R4 hour into day, R8 weekday");
        step_from(f(8'd2, 8'h24, 8'h03, 8'h15, 8'h09, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h03, 8'h15, 8'h10, 8'h00, 8'h00), "R4 hour 09->10");
    endtask

    task automatic t_month();
        step_from(f(8'd1, 8'h24, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00), "R5 April 30 ends month");
        step_from(f(8'd1, 8'h24, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00), "R5 November 30 ends month");
        step_from(f(8'd1, 8'h24, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00), "R5 January 30 continues");
        step_from(f(8'd1, 8'h24, 8'h08, 8'h31, 8'h23, 8'h59, 8'h59),
                  f(8'd2, 8'h24, 8'h09, 8'h01, 8'h00, 8'h00, 8'h00), "R5 August 31 ends month");
    endtask

    task automatic t_feb();
        step_from(f(8'd0, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                  f(8'd1, 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), "R6 year 23 Feb 28 ends");
        step_from(f(8'd0, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                  f(8'd1, 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), "R6 year 24 has Feb 29");
        step_from(f(8'd0, 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59),
                  f(8'd1, 8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), "R6 year 24 Feb 29 ends");
        step_from(f(8'd0, 8'h12, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                  f(8'd1, 8'h12, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00), "R6 year 12 odd tens leap");
        step_from(f(8'd0, 8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                  f(8'd1, 8'h10, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00), "R6 year 10 not leap");
    endtask

    task automatic t_year();
        step_from(f(8'd3, 8'h24, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
                  f(8'd4, 8'h25, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R7 new year");
        step_from(f(8'd3, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
                  f(8'd4, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00), "R7 year 99 wraps");
    endtask

    task automatic t_dow();
        step_from(f(8'd6, 8'h24, 8'h06, 8'h10, 8'h23, 8'h59, 8'h59),
                  f(8'd0, 8'h24, 8'h06, 8'h11, 8'h00, 8'h00, 8'h00), "R8 weekday 6 wraps to 0");
        step_from(f(8'd6, 8'h24, 8'h06, 8'h10, 8'h22, 8'h59, 8'h59),
                  f(8'd6, 8'h24, 8'h06, 8'h10, 8'h23, 8'h00, 8'h00), "R8 weekday holds within day");
    endtask

    task automatic t_load_wins();
        logic [55:0] w;
        do_load(f(8'd1, 8'h20, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05));
        w = f(8'd4, 8'h30, 8'h07, 8'h07, 8'h07, 8'h07, 8'h07);
        tog = ~tog;
        load_word_i = {tog, 8'hAA, w};
        @(negedge clk);
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        check_time(w, "R9 load beats coincident tick");
        @(negedge clk);
        check_time(w, "R9 tick not applied later");
    endtask

    task automatic t_flag();
        logic fl;
        logic [55:0] w;
        w = f(8'd2, 8'h24, 8'h03, 8'h15, 8'h12, 8'h00, 8'h00);
        do_load(w);
        fl = time_o[64];
        do_tick();
        check({64'd0, time_o[64]}, {64'd0, ~fl}, "R11 flag flips on tick");
        fl = time_o[64];
        do_load(time_o[55:0]);
        check({64'd0, time_o[64]}, {64'd0, fl}, "R11 flag holds on equal load");
        do_load(w);
        check({64'd0, time_o[64]}, {64'd0, ~fl}, "R11 flag flips on new load");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_tick();
        t_carry();
        t_month();
        t_feb();
        t_year();
        t_dow();
        t_load_wins();
        t_flag();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule